// File: doc/BRIEF.md
# ACPI Sleep-State Power Controller

This block turns the platform's sleep-state signals into the control levels for the power stage of a memory subsystem. It takes the enable, the wake request (high asks for the fully-on state), the S4-state USB qualifier, and a comparator flag that reports whether the main 5 V rail is above its undervoltage threshold. From these it derives six control levels. The first is the enable for the memory-rail switcher. The next two are the enables for the termination regulator and for the always-on 3.3 V LDO. The gate drive for the main-rail blocking switches is another. The last two are the active-low drives of the two standby P-channel switches, one feeding the 5 V dual rail and one feeding 5 V USB. A pair of outputs tells the gate-driver stage whether a low standby drive should use a weak, current-limited sink or a strong low-impedance pulldown.

Every input flag passes through a two-stage synchronizer. The supply undervoltage flag acts as a synchronous reset and forces the off-state pattern. After each reset a blanking window of `BLANK_CYC` clocks ignores all inputs. The memory switcher starts only when the main rail is good, and then only after a start delay of `START_CYC` clocks (about 100 µs at the system clock). Once running, it stays on for as long as the enable remains high. Entry to the fully-on state likewise waits for the main rail.

Top module: `acpi_sleep_ctrl`

## Requirements
- R1: While `vcc_ok` is low, and at any time `en_req` is low, the outputs show the off pattern: `mem_en`=0, `term_en`=0, `ldo_en`=1, `blk_drv`=0, `dual_drv`=1, `usb_drv`=1, `sink_weak`=0, `sink_strong`=0.
- R2: With `en_req`=1 and the controller not in the on state, the sleep pattern holds: `ldo_en`=1, `blk_drv`=0, `dual_drv`=0, `term_en`=0.
- R3: In the sleep pattern, `usb_drv` is 0 when `usb_s4` is 1 and is 1 when `usb_s4` is 0.
- R4: In the on state, `blk_drv`=1, `dual_drv`=1, `usb_drv`=1 and `ldo_en`=0. `ldo_en` is always the complement of `blk_drv`.
- R5: A `wake_req`=1 with `main_ok`=0 keeps the sleep pattern. The on state is entered only once `main_ok` is 1. A later drop of `main_ok` does not leave the on state.
- R6: `mem_en` rises only after `main_ok`, `en_req` and the end of blanking have been continuously true for `START_CYC` clocks. It is still 0 `START_CYC` clocks after the inputs are applied and is 1 by `START_CYC`+6 clocks. Once on, it stays on while `en_req`=1, whatever the level of `main_ok`.
- R7: `term_en` is 1 exactly when the controller is in the on state and `mem_en` is 1.
- R8: When either standby drive is low, `sink_weak`=1 if `main_ok`=0 and `sink_strong`=1 if `main_ok`=1. Both are 0 when both drives are high, and they are never 1 together.
- R9: For `BLANK_CYC` clocks after `vcc_ok` rises, every input is ignored and the R1 pattern holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| vcc_ok | input | 1 | Supply above UVLO; low acts as a synchronous reset |
| en_req | input | 1 | Platform enable; low selects the off state |
| wake_req | input | 1 | High requests the fully-on state, low the sleep state |
| usb_s4 | input | 1 | High lets the USB standby switch turn on during sleep |
| main_ok | input | 1 | Main 5 V rail above its UVLO threshold |
| mem_en | output | 1 | Memory-rail switcher enable |
| term_en | output | 1 | Termination regulator enable |
| ldo_en | output | 1 | Always-on 3.3 V LDO enable |
| blk_drv | output | 1 | Main-rail blocking-switch gate drive, high = pass |
| dual_drv | output | 1 | 5 V dual standby switch drive, low = switch on |
| usb_drv | output | 1 | 5 V USB standby switch drive, low = switch on |
| sink_weak | output | 1 | Low standby drive uses the current-limited sink |
| sink_strong | output | 1 | Low standby drive uses the hard pulldown |

## Verification
The embedded assertions check on every cycle the cross-output invariants. These are that the LDO enable and the blocking drive are complementary, that termination implies the switcher is on, and that the weak and strong sinks exclude each other. They also check that the on state is entered only on a cycle where the synchronized main-rail flag is true, that blanking leaves only for the off state, and that the switcher turns on only when its start counter has reached its final count. Only the bench scenarios can show the full output pattern for each input combination. The same holds for the USB qualifier, the stay-on behaviour after the main rail drops, the exact start-delay window, and the re-blanking after a supply dropout.

// File: rtl/acpi_pkg.sv
package acpi_pkg;
  typedef enum logic [1:0] {
    PS_BLANK = 2'd0,
    PS_OFF   = 2'd1,
    PS_SLEEP = 2'd2,
    PS_ON    = 2'd3
  } pwr_state_t;

  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_WAIT = 2'd1,
    MS_RUN  = 2'd2
  } mem_state_t;
endpackage

// File: rtl/acpi_sync.sv
module acpi_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= '0;
        else if (g == 0) chain[g] <= d_in;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/acpi_state_fsm.sv
module acpi_state_fsm
  import acpi_pkg::*;
#(
  parameter int BLANK_CYC = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_s,
  input  logic       wake_s,
  input  logic       main_s,
  output pwr_state_t pstate
);
  localparam int CW = $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] B_LAST = CW'(BLANK_CYC - 1);

  logic [CW-1:0] bcnt;
  logic          go_on;

  assign go_on = wake_s && main_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pstate <= PS_BLANK;
      bcnt   <= '0;
    end else begin
      unique case (pstate)
        PS_BLANK: begin
          if (bcnt == B_LAST) pstate <= PS_OFF;
          else bcnt <= bcnt + 1'b1;
        end
        PS_OFF: begin
          if (en_s) pstate <= go_on ? PS_ON : PS_SLEEP;
        end
        PS_SLEEP: begin
          if (!en_s) pstate <= PS_OFF;
          else if (go_on) pstate <= PS_ON;
        end
        PS_ON: begin
          if (!en_s) pstate <= PS_OFF;
          else if (!wake_s) pstate <= PS_SLEEP;
        end
        default: pstate <= PS_OFF;
      endcase
    end
  end

  // R5: the on state is reached only on a cycle where the main rail was good
  assert_on_needs_main_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == PS_ON && $past(pstate) != PS_ON) |-> $past(main_s));

  // R9: blanking can only hold or give way to the off state
  assert_blank_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == PS_BLANK) |=> (pstate == PS_BLANK || pstate == PS_OFF));
endmodule

// File: rtl/acpi_mem_seq.sv
module acpi_mem_seq
  import acpi_pkg::*;
#(
  parameter int START_CYC = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic allow,
  input  logic start_ok,
  output logic mem_on
);
  localparam int CW = $clog2(START_CYC + 1);
  localparam logic [CW-1:0] S_LAST = CW'(START_CYC - 1);

  mem_state_t    mstate;
  logic [CW-1:0] scnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mstate <= MS_IDLE;
      scnt   <= '0;
    end else begin
      unique case (mstate)
        MS_IDLE: begin
          scnt <= '0;
          if (allow && start_ok) mstate <= MS_WAIT;
        end
        MS_WAIT: begin
          if (!(allow && start_ok)) begin
            mstate <= MS_IDLE;
            scnt   <= '0;
          end else if (scnt == S_LAST) begin
            mstate <= MS_RUN;
          end else begin
            scnt <= scnt + 1'b1;
          end
        end
        MS_RUN: begin
          if (!allow) mstate <= MS_IDLE;
        end
        default: mstate <= MS_IDLE;
      endcase
    end
  end

  assign mem_on = (mstate == MS_RUN);

  // R6: the switcher starts only once the delay counter has run out
  assert_start_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mstate == MS_RUN && $past(mstate) != MS_RUN) |->
      ($past(mstate) == MS_WAIT && $past(scnt) == S_LAST));

  // R6: a running switcher is kept while allowed
  assert_run_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mstate == MS_RUN && allow) |=> (mstate == MS_RUN));
endmodule

// File: rtl/acpi_out_dec.sv
module acpi_out_dec
  import acpi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pwr_state_t pstate,
  input  logic       mem_on,
  input  logic       usb_s,
  input  logic       main_s,
  output logic       mem_en,
  output logic       term_en,
  output logic       ldo_en,
  output logic       blk_drv,
  output logic       dual_drv,
  output logic       usb_drv,
  output logic       sink_weak,
  output logic       sink_strong
);
  logic n_ldo, n_blk, n_dual, n_usb, n_low;

  always_comb begin
    unique case (pstate)
      PS_SLEEP: begin
        n_ldo = 1'b1; n_blk = 1'b0; n_dual = 1'b0; n_usb = ~usb_s;
      end
      PS_ON: begin
        n_ldo = 1'b0; n_blk = 1'b1; n_dual = 1'b1; n_usb = 1'b1;
      end
      default: begin
        n_ldo = 1'b1; n_blk = 1'b0; n_dual = 1'b1; n_usb = 1'b1;
      end
    endcase
    n_low = ~n_dual | ~n_usb;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_en      <= 1'b0;
      term_en     <= 1'b0;
      ldo_en      <= 1'b1;
      blk_drv     <= 1'b0;
      dual_drv    <= 1'b1;
      usb_drv     <= 1'b1;
      sink_weak   <= 1'b0;
      sink_strong <= 1'b0;
    end else begin
      mem_en      <= mem_on;
      term_en     <= mem_on && (pstate == PS_ON);
      ldo_en      <= n_ldo;
      blk_drv     <= n_blk;
      dual_drv    <= n_dual;
      usb_drv     <= n_usb;
      sink_weak   <= n_low && !main_s;
      sink_strong <= n_low && main_s;
    end
  end
endmodule

// File: rtl/acpi_sleep_ctrl.sv
module acpi_sleep_ctrl
  import acpi_pkg::*;
#(
  parameter int BLANK_CYC = 100000,
  parameter int START_CYC = 5000,
  parameter int SYNC_STG  = 2
) (
  input  logic clk,
  input  logic vcc_ok,
  input  logic en_req,
  input  logic wake_req,
  input  logic usb_s4,
  input  logic main_ok,
  output logic mem_en,
  output logic term_en,
  output logic ldo_en,
  output logic blk_drv,
  output logic dual_drv,
  output logic usb_drv,
  output logic sink_weak,
  output logic sink_strong
);
  localparam int NFLAG = 4;

  logic [NFLAG-1:0] raw_f, syn_f;
  logic             en_s, wake_s, usb_s, main_s;
  pwr_state_t       pstate;
  logic             mem_on;
  logic             mem_allow;

  assign raw_f = {main_ok, usb_s4, wake_req, en_req};
  assign {main_s, usb_s, wake_s, en_s} = syn_f;

  acpi_sync #(.WIDTH(NFLAG), .STAGES(SYNC_STG)) u_sync (
    .clk   (clk),
    .rst_n (vcc_ok),
    .d_in  (raw_f),
    .d_out (syn_f)
  );

  acpi_state_fsm #(.BLANK_CYC(BLANK_CYC)) u_fsm (
    .clk    (clk),
    .rst_n  (vcc_ok),
    .en_s   (en_s),
    .wake_s (wake_s),
    .main_s (main_s),
    .pstate (pstate)
  );

  assign mem_allow = en_s && (pstate != PS_BLANK);

  acpi_mem_seq #(.START_CYC(START_CYC)) u_mem (
    .clk      (clk),
    .rst_n    (vcc_ok),
    .allow    (mem_allow),
    .start_ok (main_s),
    .mem_on   (mem_on)
  );

  acpi_out_dec u_dec (
    .clk         (clk),
    .rst_n       (vcc_ok),
    .pstate      (pstate),
    .mem_on      (mem_on),
    .usb_s       (usb_s),
    .main_s      (main_s),
    .mem_en      (mem_en),
    .term_en     (term_en),
    .ldo_en      (ldo_en),
    .blk_drv     (blk_drv),
    .dual_drv    (dual_drv),
    .usb_drv     (usb_drv),
    .sink_weak   (sink_weak),
    .sink_strong (sink_strong)
  );

  assert_ldo_vs_blk_R4: assert property (@(posedge clk) disable iff (!vcc_ok)
    ldo_en != blk_drv);

  assert_term_needs_mem_R7: assert property (@(posedge clk) disable iff (!vcc_ok)
    term_en |-> mem_en);

  assert_sink_excl_R8: assert property (@(posedge clk) disable iff (!vcc_ok)
    !(sink_weak && sink_strong));

  assert_sink_only_low_R8: assert property (@(posedge clk) disable iff (!vcc_ok)
    (sink_weak || sink_strong) |-> (!dual_drv || !usb_drv));

  assert_on_drives_high_R4: assert property (@(posedge clk) disable iff (!vcc_ok)
    blk_drv |-> (dual_drv && usb_drv));
endmodule

// File: tb/tb_acpi_sleep_ctrl.sv
module tb_acpi_sleep_ctrl;
  localparam int BLANK = 40;
  localparam int START = 20;

  logic clk = 1'b0;
  logic vcc_ok = 1'b0, en_req = 1'b0, wake_req = 1'b0, usb_s4 = 1'b0, main_ok = 1'b0;
  logic mem_en, term_en, ldo_en, blk_drv, dual_drv, usb_drv, sink_weak, sink_strong;

  int n_chk = 0, n_bad = 0;
  int m_ps = 0;      // 0 off, 1 sleep, 2 on
  bit m_mem = 0;
  bit done = 0;

  always #10 clk = ~clk;

  acpi_sleep_ctrl #(.BLANK_CYC(BLANK), .START_CYC(START)) dut (
    .clk(clk), .vcc_ok(vcc_ok), .en_req(en_req), .wake_req(wake_req),
    .usb_s4(usb_s4), .main_ok(main_ok), .mem_en(mem_en), .term_en(term_en),
    .ldo_en(ldo_en), .blk_drv(blk_drv), .dual_drv(dual_drv), .usb_drv(usb_drv),
    .sink_weak(sink_weak), .sink_strong(sink_strong));

  function automatic logic [7:0] pat(int ps, bit mem, bit usb, bit mn);
    logic l, b, d, u, low;
    if (ps == 1) begin l = 1; b = 0; d = 0; u = !usb; end
    else if (ps == 2) begin l = 0; b = 1; d = 1; u = 1; end
    else begin l = 1; b = 0; d = 1; u = 1; end
    low = !d || !u;
    return {mem, mem && (ps == 2), l, b, d, u, low && !mn, low && mn};
  endfunction

  function automatic logic [7:0] outs();
    return {mem_en, term_en, ldo_en, blk_drv, dual_drv, usb_drv, sink_weak, sink_strong};
  endfunction

  task automatic check(string req, logic [7:0] exp);
    n_chk++;
    if (outs() !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, outs(), exp);
    end
  endtask

  task automatic check_bit(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic model_step(bit e, bit w, bit mn);
    if (!e) begin m_ps = 0; m_mem = 0; end
    else begin
      if (w && mn) m_ps = 2;
      else if (!w) m_ps = 1;
      else if (m_ps != 2) m_ps = 1;
      if (!m_mem) m_mem = mn;
    end
  endtask

  task automatic apply(bit e, bit w, bit u, bit mn);
    en_req = e; wake_req = w; usb_s4 = u; main_ok = mn;
    model_step(e, w, mn);
  endtask

  task automatic power_up();
    vcc_ok = 0; m_ps = 0; m_mem = 0;
    wait_cyc(3);
    vcc_ok = 1;
    wait_cyc(BLANK + 6);
  endtask

  initial begin
    @(negedge clk);
    wait_cyc(3);
    check("R1 reset pattern", pat(0, 0, 0, 0));

    // R9: inputs fully asserted during blanking are ignored
    en_req = 1; wake_req = 1; main_ok = 1; usb_s4 = 1;
    vcc_ok = 1;
    wait_cyc(BLANK - 2);
    check("R9 blanking ignores inputs", pat(0, 0, 1, 1));
    en_req = 0; wake_req = 0; main_ok = 0; usb_s4 = 0;
    wait_cyc(12);
    check("R1 off after blanking", pat(0, 0, 0, 0));

    // R6: start delay window from the off state
    apply(1, 0, 0, 1);
    wait_cyc(START);
    check_bit("R6 mem_en still low", mem_en, 1'b0);
    check("R2 sleep pattern strong sink R8", pat(1, 0, 0, 1));
    wait_cyc(6);
    check_bit("R6 mem_en high after delay", mem_en, 1'b1);

    // R3: USB qualifier in sleep
    apply(1, 0, 1, 1);
    wait_cyc(8);
    check("R3 usb drive low with qualifier", pat(1, 1, 1, 1));

    // R5: wake with main rail low keeps sleep, weak sink
    apply(0, 0, 0, 0); wait_cyc(8);
    check("R1 en low gives off", pat(0, 0, 0, 0));
    apply(1, 1, 1, 0); wait_cyc(40);
    check("R5 wake blocked by main rail R8 weak", pat(1, 0, 1, 0));
    check_bit("R6 no start without main rail", mem_en, 1'b0);
    apply(1, 1, 1, 1); wait_cyc(40);
    check("R4 R7 on state after main rail", pat(2, 1, 1, 1));
    apply(1, 1, 1, 0); wait_cyc(40);
    check("R5 R6 main drop keeps on state", pat(2, 1, 1, 0));

    // R1: supply dropout returns to off and re-blanks
    vcc_ok = 0; wait_cyc(2);
    check("R1 uvlo reset pattern", pat(0, 0, 1, 0));
    apply(1, 1, 0, 1);
    power_up();
    m_ps = 0; m_mem = 0; model_step(1, 1, 1);
    wait_cyc(40);
    check("R9 R4 resume after reblank", pat(m_ps, m_mem, 0, 1));

    // Random held vectors
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 80; i++) begin
      bit e, w, u, mn;
      e = ($urandom % 5) != 0; w = $urandom % 2; u = $urandom % 2; mn = ($urandom % 3) != 0;
      apply(e, w, u, mn);
      wait_cyc(START + 15);
      check("R1 R2 R3 R4 R5 R6 R7 R8 random", pat(m_ps, m_mem, u, mn));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule